// File: doc/BRIEF.md
# Four-Slot Issue Group Validator

This block sits at the end of the decode stage of a superscalar integer and floating-point core. Each cycle it receives up to four decoded instructions in program order. Each instruction carries a small class code and a lane-valid bit. The block works out how long a prefix of those instructions can leave together as one issue group. It walks the lanes in order and gives each accepted instruction the next free issue slot and a function unit. The walk stops at the first instruction whose unit, slot-position or ordering rule fails.

The shared resources are the issue slots, two integer units that are not alike, one load/store unit, one control-transfer unit, and two single-precision and two double-precision floating pipes. Unit 0 is the only integer unit that can shift. Unit 1 is the only one that can compare. Plain ALU work can go to either unit, but unit 0 must be taken before unit 1 within a group. Some classes must issue alone. A group may not mix floating precisions. Operand dependences are checked elsewhere and play no part here.

The result is registered: the group length and the per-lane unit codes appear on the outputs one clock after the lanes are presented.

Top module: `issue_group_validator`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), `out_vld` is 0, `out_count` is 0 and every lane unit code is 0.
- R2: The outputs reflect the inputs of the previous clock edge. When `in_vld` was low, the next cycle shows `out_vld` = 0, `out_count` = 0 and all unit codes 0.
- R3: Accepted lane k occupies slot k. Classes ALU (0), SHIFT (1), COMPARE (2), LOAD (3) and STORE (4) are accepted only in lanes 0 to 2. Branch and FP classes may take any lane.
- R4: Unit codes are 0 none, 1 integer unit 0, 2 integer unit 1, 3 load/store, 4 control transfer, 5 FP single, 6 FP double, 7 whole group. SHIFT needs integer unit 0 and COMPARE needs integer unit 1. ALU takes unit 0 when both units are free, otherwise unit 1.
- R5: Once integer unit 1 is in use, no later lane may claim integer unit 0, so a SHIFT or an ALU that needs unit 0 ends the group.
- R6: Class SOLO (9) is accepted only in lane 0, reports unit code 7, and gives a group length of exactly 1.
- R7: Class CALL (6) is accepted only in lane 0. It claims the control-transfer unit and integer unit 1 and reports unit code 4.
- R8: FP single (7) and FP double (8) never share a group, and at most two instructions of one precision are accepted.
- R9: At most one LOAD/STORE and at most one control-transfer instruction (BRANCH 5 or CALL 6) are accepted per group.
- R10: The group ends before the first lane whose valid bit is clear or whose class code is 10 to 15. Lanes at or beyond `out_count` report unit code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A set of candidate instructions is presented |
| lane_vld | input | 4 | Per-lane valid, lane 0 is oldest |
| lane_cls | input | 16 | Four 4-bit class codes, lane 0 in bits 3:0 |
| out_vld | output | 1 | Result valid |
| out_count | output | 3 | Number of leading lanes that issue (0 to 4) |
| out_unit | output | 12 | Four 3-bit unit codes, lane 0 in bits 2:0 |

## Verification
The only internal state is the resource record passed from lane to lane. If a claim flag is dropped or set wrongly, the effect appears in the same registered result, one cycle after the stimulus. It shows as a group that is too long or too short, a duplicated unit, or an integer unit 1 lane placed before an integer unit 0 lane. The bench therefore compares every cycle's count and all four unit codes against a behavioural model. It mixes directed groups that sit on each rule's edge with a long weighted-random stream.

// File: rtl/igv_pkg.sv
package igv_pkg;
   localparam int CLS_W  = 4;
   localparam int UNIT_W = 3;

   localparam logic [CLS_W-1:0] C_ALU  = 4'd0;
   localparam logic [CLS_W-1:0] C_SHF  = 4'd1;
   localparam logic [CLS_W-1:0] C_CMP  = 4'd2;
   localparam logic [CLS_W-1:0] C_LD   = 4'd3;
   localparam logic [CLS_W-1:0] C_ST   = 4'd4;
   localparam logic [CLS_W-1:0] C_BR   = 4'd5;
   localparam logic [CLS_W-1:0] C_CALL = 4'd6;
   localparam logic [CLS_W-1:0] C_FPS  = 4'd7;
   localparam logic [CLS_W-1:0] C_FPD  = 4'd8;
   localparam logic [CLS_W-1:0] C_SOLO = 4'd9;

   localparam logic [UNIT_W-1:0] U_NONE = 3'd0;
   localparam logic [UNIT_W-1:0] U_IEU0 = 3'd1;
   localparam logic [UNIT_W-1:0] U_IEU1 = 3'd2;
   localparam logic [UNIT_W-1:0] U_LSU  = 3'd3;
   localparam logic [UNIT_W-1:0] U_CTI  = 3'd4;
   localparam logic [UNIT_W-1:0] U_FPS  = 3'd5;
   localparam logic [UNIT_W-1:0] U_FPD  = 3'd6;
   localparam logic [UNIT_W-1:0] U_ALL  = 3'd7;

   // resources claimed by the lanes accepted so far
   typedef struct packed {
      logic       stop;
      logic       ieu0;
      logic       ieu1;
      logic       lsu;
      logic       cti;
      logic [1:0] nfps;
      logic [1:0] nfpd;
   } grp_state_t;
endpackage

// File: rtl/igv_lane.sv
module igv_lane
   import igv_pkg::*;
#(
   parameter int IDX       = 0,
   parameter int INT_SLOTS = 3,
   parameter int FP_PIPES  = 2
) (
   input  logic              vld,
   input  logic [CLS_W-1:0]  cls,
   input  grp_state_t        st_in,
   output logic              ok,
   output logic [UNIT_W-1:0] unit,
   output grp_state_t        st_out
);
   localparam bit         INT_OK = (IDX < INT_SLOTS);
   localparam bit         HEAD   = (IDX == 0);
   localparam logic [1:0] FP_LIM = 2'(FP_PIPES);

   always_comb begin
      ok     = 1'b0;
      unit   = U_NONE;
      st_out = st_in;
      if (!st_in.stop && vld) begin
         case (cls)
            C_ALU: begin
               if (INT_OK && !st_in.ieu0 && !st_in.ieu1) begin
                  ok = 1'b1; unit = U_IEU0; st_out.ieu0 = 1'b1;
               end else if (INT_OK && !st_in.ieu1) begin
                  ok = 1'b1; unit = U_IEU1; st_out.ieu1 = 1'b1;
               end
            end
            C_SHF: begin
               if (INT_OK && !st_in.ieu0 && !st_in.ieu1) begin
                  ok = 1'b1; unit = U_IEU0; st_out.ieu0 = 1'b1;
               end
            end
            C_CMP: begin
               if (INT_OK && !st_in.ieu1) begin
                  ok = 1'b1; unit = U_IEU1; st_out.ieu1 = 1'b1;
               end
            end
            C_LD, C_ST: begin
               if (INT_OK && !st_in.lsu) begin
                  ok = 1'b1; unit = U_LSU; st_out.lsu = 1'b1;
               end
            end
            C_BR: begin
               if (!st_in.cti) begin
                  ok = 1'b1; unit = U_CTI; st_out.cti = 1'b1;
               end
            end
            C_CALL: begin
               if (HEAD && !st_in.cti && !st_in.ieu1) begin
                  ok = 1'b1; unit = U_CTI;
                  st_out.cti  = 1'b1;
                  st_out.ieu1 = 1'b1;
               end
            end
            C_FPS: begin
               if (st_in.nfpd == 2'd0 && st_in.nfps < FP_LIM) begin
                  ok = 1'b1; unit = U_FPS; st_out.nfps = st_in.nfps + 2'd1;
               end
            end
            C_FPD: begin
               if (st_in.nfps == 2'd0 && st_in.nfpd < FP_LIM) begin
                  ok = 1'b1; unit = U_FPD; st_out.nfpd = st_in.nfpd + 2'd1;
               end
            end
            C_SOLO: begin
               if (HEAD) begin
                  ok = 1'b1; unit = U_ALL; st_out.stop = 1'b1;
               end
            end
            default: ;
         endcase
      end
      if (!ok) st_out.stop = 1'b1;
   end
endmodule

// File: rtl/igv_tally.sv
module igv_tally #(
   parameter int N  = 4,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  ok,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) cnt = cnt + CW'(ok[i]);
   end
endmodule

// File: rtl/issue_group_validator.sv
module issue_group_validator
   import igv_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int INT_SLOTS = 3,
   parameter int FP_PIPES  = 2,
   localparam int CNT_W    = $clog2(LANES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [LANES-1:0]          lane_vld,
   input  logic [LANES*CLS_W-1:0]    lane_cls,
   output logic                      out_vld,
   output logic [CNT_W-1:0]          out_count,
   output logic [LANES*UNIT_W-1:0]   out_unit
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("LANES must lie in 1..8");
   end
   if (INT_SLOTS < 1 || INT_SLOTS > LANES) begin : g_bad_int
      $error("INT_SLOTS must lie in 1..LANES");
   end
   if (FP_PIPES < 1 || FP_PIPES > 3) begin : g_bad_fp
      $error("FP_PIPES must lie in 1..3");
   end

   grp_state_t                st [LANES+1];
   logic [LANES-1:0]          lane_ok;
   logic [LANES*UNIT_W-1:0]   lane_unit;
   logic [CNT_W-1:0]          grp_cnt;

   assign st[0] = '0;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      igv_lane #(
         .IDX       (g),
         .INT_SLOTS (INT_SLOTS),
         .FP_PIPES  (FP_PIPES)
      ) u_lane (
         .vld    (lane_vld[g]),
         .cls    (lane_cls[g*CLS_W +: CLS_W]),
         .st_in  (st[g]),
         .ok     (lane_ok[g]),
         .unit   (lane_unit[g*UNIT_W +: UNIT_W]),
         .st_out (st[g+1])
      );
   end

   igv_tally #(.N(LANES), .CW(CNT_W)) u_tally (
      .ok  (lane_ok),
      .cnt (grp_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_count <= '0;
         out_unit  <= '0;
      end else begin
         out_vld   <= in_vld;
         out_count <= in_vld ? grp_cnt : '0;
         out_unit  <= in_vld ? lane_unit : '0;
      end
   end

   // ---- output decode used by the checks below ----
   logic [LANES-1:0] is_i0, is_i1, is_ls, is_ct, is_fs, is_fd, is_all, is_none;
   for (genvar g = 0; g < LANES; g++) begin : g_dec
      assign is_i0[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_IEU0;
      assign is_i1[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_IEU1;
      assign is_ls[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_LSU;
      assign is_ct[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_CTI;
      assign is_fs[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_FPS;
      assign is_fd[g]   = out_unit[g*UNIT_W +: UNIT_W] == U_FPD;
      assign is_all[g]  = out_unit[g*UNIT_W +: UNIT_W] == U_ALL;
      assign is_none[g] = out_unit[g*UNIT_W +: UNIT_W] == U_NONE;

      a_r10_tail_none: assert property (@(posedge clk) disable iff (!rst_n)
         (out_count <= CNT_W'(g)) |-> is_none[g]);

      if (g > 0) begin : g_ord
         a_r5_ieu_order: assert property (@(posedge clk) disable iff (!rst_n)
            is_i0[g] |-> (is_i1[g-1:0] == '0));
      end
      if (g >= INT_SLOTS) begin : g_hi
         a_r3_int_slot: assert property (@(posedge clk) disable iff (!rst_n)
            !(is_i0[g] || is_i1[g] || is_ls[g]));
      end
   end

   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && out_count == '0));
   a_r4_one_ieu0: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_i0) <= 1 && $countones(is_i1) <= 1);
   a_r6_solo_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (|is_all) |-> (is_all[0] && out_count == CNT_W'(1)));
   a_r8_fp_mix: assert property (@(posedge clk) disable iff (!rst_n)
      !((|is_fs) && (|is_fd)));
   a_r9_one_lsu_cti: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_ls) <= 1 && $countones(is_ct) <= 1);
   a_r10_full_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !st[LANES].stop) |=> out_count == CNT_W'(LANES));
endmodule

// File: tb/issue_group_validator_tb.sv
`timescale 1ns/1ps
module issue_group_validator_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [3:0]  lane_vld = '0;
   logic [15:0] lane_cls = '0;
   logic        out_vld;
   logic [2:0]  out_count;
   logic [11:0] out_unit;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic        exp_vld;
   int          exp_cnt;
   logic [11:0] exp_units;
   bit          pend = 0;
   string       exp_tag;

   always #2 clk = ~clk;

   issue_group_validator u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .lane_vld(lane_vld),
      .lane_cls(lane_cls), .out_vld(out_vld), .out_count(out_count),
      .out_unit(out_unit)
   );

   function automatic logic [15:0] pk(int c0, int c1, int c2, int c3);
      return {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
   endfunction

   // behavioural reference: walk the lanes with plain resource counters
   task automatic model(input logic [15:0] c, input logic [3:0] v,
                        output int cnt, output logic [11:0] units);
      bit i0 = 0, i1 = 0, ls = 0, ct = 0, stop = 0;
      int nfs = 0, nfd = 0;
      cnt = 0; units = '0;
      for (int k = 0; k < 4; k++) begin
         int cl = int'(c[k*4 +: 4]);
         int u = 0;
         if (stop || !v[k]) begin stop = 1; continue; end
         case (cl)
            0: if (k < 3 && !i1) begin if (!i0) begin u = 1; i0 = 1; end else begin u = 2; i1 = 1; end end
            1: if (k < 3 && !i0 && !i1) begin u = 1; i0 = 1; end
            2: if (k < 3 && !i1) begin u = 2; i1 = 1; end
            3, 4: if (k < 3 && !ls) begin u = 3; ls = 1; end
            5: if (!ct) begin u = 4; ct = 1; end
            6: if (k == 0) begin u = 4; ct = 1; i1 = 1; end
            7: if (nfd == 0 && nfs < 2) begin u = 5; nfs++; end
            8: if (nfs == 0 && nfd < 2) begin u = 6; nfd++; end
            9: if (k == 0) begin u = 7; stop = 1; end
            default: u = 0;
         endcase
         if (u == 0) stop = 1;
         else begin units[k*3 +: 3] = 3'(u); cnt++; end
      end
   endtask

   task automatic check_prev();
      if (pend) begin
         checks++;
         if (out_vld !== exp_vld || int'(out_count) != exp_cnt || out_unit !== exp_units) begin
            fails++;
            $display("FAIL %s: got vld=%0b cnt=%0d units=%h, expected vld=%0b cnt=%0d units=%h",
                     exp_tag, out_vld, out_count, out_unit, exp_vld, exp_cnt, exp_units);
         end
      end
   endtask

   task automatic apply(input logic iv, input logic [3:0] v, input logic [15:0] c,
                        input string tag);
      @(negedge clk);
      check_prev();
      in_vld = iv; lane_vld = v; lane_cls = c;
      if (iv) model(c, v, exp_cnt, exp_units);
      else begin exp_cnt = 0; exp_units = '0; end
      exp_vld = iv; exp_tag = tag; pend = 1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_vld !== 1'b0 || out_count !== 3'd0 || out_unit !== 12'd0) begin
         fails++;
         $display("FAIL R1: got vld=%0b cnt=%0d units=%h, expected 0 0 000", out_vld, out_count, out_unit);
      end
      rst_n = 1'b1;

      apply(1, 4'hF, pk(0, 0, 0, 7), "R4 alu,alu,alu");
      apply(1, 4'hF, pk(0, 2, 7, 5), "R4 alu,cmp,fps,br");
      apply(1, 4'hF, pk(1, 2, 3, 8), "R4 shf,cmp,ld,fpd");
      apply(1, 4'hF, pk(2, 0, 7, 7), "R5 cmp then alu");
      apply(1, 4'hF, pk(2, 1, 7, 7), "R5 cmp then shf");
      apply(1, 4'hF, pk(0, 1, 7, 7), "R5 alu then shf");
      apply(1, 4'hF, pk(7, 7, 5, 0), "R3 alu in lane 3");
      apply(1, 4'hF, pk(7, 5, 7, 3), "R3 load in lane 3");
      apply(1, 4'hF, pk(7, 8, 7, 7), "R8 mix");
      apply(1, 4'hF, pk(8, 8, 8, 5), "R8 three doubles");
      apply(1, 4'hF, pk(9, 0, 0, 0), "R6 solo first");
      apply(1, 4'hF, pk(0, 9, 0, 0), "R6 solo second");
      apply(1, 4'hF, pk(6, 7, 0, 7), "R7 call then alu");
      apply(1, 4'hF, pk(6, 7, 2, 7), "R7 call then cmp");
      apply(1, 4'hF, pk(0, 6, 7, 7), "R7 call not first");
      apply(1, 4'hF, pk(3, 4, 7, 7), "R9 two lsu");
      apply(1, 4'hF, pk(5, 7, 5, 7), "R9 two cti");
      apply(1, 4'hF, pk(0, 12, 7, 7), "R10 bad class");
      apply(1, 4'b1101, pk(0, 7, 7, 7), "R10 lane gap");
      apply(1, 4'h0, pk(0, 0, 0, 0), "R10 no lanes");
      apply(0, 4'hF, pk(0, 2, 7, 5), "R2 idle");
      apply(1, 4'hF, pk(7, 7, 7, 7), "R8 four singles");

      for (int n = 0; n < 4000; n++) begin
         logic [15:0] c;
         logic [3:0]  v;
         for (int k = 0; k < 4; k++)
            c[k*4 +: 4] = ($urandom_range(0, 11) == 0) ? 4'($urandom_range(10, 15))
                                                       : 4'($urandom_range(0, 9));
         v = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
         apply(($urandom_range(0, 9) != 0), v, c, "R3/R4/R5/R8/R9 random");
      end
      apply(0, 4'h0, 16'h0, "R2 flush");
      @(negedge clk);
      check_prev();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule